// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This block is the host-facing register file of a single descriptor-driven DMA channel. A host reaches it through a 32-bit port that only accepts whole, word-aligned accesses. Through that port the host starts, pauses, wakes and stops the channel, points it at a descriptor list, and sets the selector words that the descriptor sequencer uses to evaluate its interrupt, branch and wait conditions.

Control writes do not store a value directly. The upper half of the written word is a per-bit enable, and the lower half gives the new bit values. The unit turns each control write into a new channel status word and decides whether the channel is active. If the write stops or pauses the channel, or asks for a flush, the unit first runs a request/acknowledge handshake with the attached device. It commits the new status only when that handshake completes. When a commit leaves the channel active, the unit sends the sequencer a one-cycle kick. An accepted write to the command pointer sends the sequencer a one-cycle descriptor-fetch pulse.

The sequencer reports its own events back on dedicated inputs. These are: a descriptor was fetched, the channel halted, the channel died, or a branch was decided.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero and flushReq, kick and fetchReq are low.
- R2: A control write (word offset 0x00) changes only status bits whose enable bit (written bit 16+n) is set. RUN is status bit 15; writing it as 1 sets RUN, and writing it as 0 clears both RUN and DEAD (bit 11).
- R3: WAKE (bit 12) is set by a control write only when it is enabled, written as 1, and RUN is 1 after the same write.
- R4: PAUSE (bit 14) takes the written value whenever its enable bit is set.
- R5: ACTIVE (bit 10) is cleared by a control write that leaves PAUSE set or RUN clear. Otherwise it is set if the write enabled RUN or PAUSE, or requested WAKE, and it is unchanged in all other cases. ACTIVE is never 1 while RUN is 0 or PAUSE is 1.
- R6: A control write that leaves PAUSE set or RUN clear, or that writes FLUSH (bit 13) as 1 under its enable, raises flushReq in the cycle after the write. flushReq then stays high until flushAck is seen, and the new status is committed at that acknowledge edge. Control writes that arrive while flushReq is high are dropped. A control write that needs no flush commits at its own clock edge.
- R7: Status FLUSH is 1 only while flushReq is high and the pending write requested a flush. The commit clears it.
- R8: kick is a one-cycle pulse in the cycle after any status commit that leaves ACTIVE set, and it is low after a commit that leaves ACTIVE clear.
- R9: A write to the low command pointer (0x0C) is ignored while ACTIVE is 1. An accepted write stores the value with bits 3:0 cleared, and fetchReq pulses for one cycle after it.
- R10: Reads at 0x00 and 0x04 return the status word, with bits 31:16 zero. The select words at 0x10 (interrupt), 0x14 (branch) and 0x18 (wait) read back all 32 written bits. The high pointer at 0x08, every word offset from 0x1C up, and any access with address bits 1:0 not zero read as zero.
- R11: A write to the status offset 0x04 changes only the device status bits 7:0.
- R12: Sequencer inputs act on status when no commit happens in the same cycle: seqFetch clears WAKE, seqHalt clears ACTIVE, seqKill sets DEAD and clears ACTIVE, and seqBranch loads BT (bit 8) from seqBtVal. A commit in the same cycle takes precedence over them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| flushReq | output | 1 | Flush request to the attached device |
| flushAck | input | 1 | Flush done from the attached device |
| kick | output | 1 | Pulse telling the sequencer the channel is active |
| fetchReq | output | 1 | Pulse asking the sequencer to fetch the descriptor at cmdPtr |
| cmdPtr | output | 32 | Current command pointer |
| chanStatus | output | 16 | Current status word |
| intSel | output | 32 | Interrupt condition select word |
| brSel | output | 32 | Branch condition select word |
| waitSel | output | 32 | Wait condition select word |
| seqFetch | input | 1 | Sequencer fetched a descriptor (clears WAKE) |
| seqHalt | input | 1 | Sequencer stopped (clears ACTIVE) |
| seqKill | input | 1 | Sequencer hit a fatal error (sets DEAD) |
| seqBranch | input | 1 | Sequencer branch decision valid |
| seqBtVal | input | 1 | Branch-taken value loaded into BT |

## Verification
The bench uses the default parameters: an 8-bit byte address, an 8-bit device status field and a 4-bit pointer alignment. With an 8-bit address the bench can reach offsets beyond the seven defined words, so the zero-read default and the misaligned-access rule get exercised, not only the defined registers. The 16-byte alignment lets the bench see low pointer bits being dropped on a written pointer.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // status bit positions
  localparam int BIT_RUN    = 15;
  localparam int BIT_PAUSE  = 14;
  localparam int BIT_FLUSH  = 13;
  localparam int BIT_WAKE   = 12;
  localparam int BIT_DEAD   = 11;
  localparam int BIT_ACTIVE = 10;
  localparam int BIT_BT     = 8;

  // word indices of the register window
  localparam int OFS_CTRL  = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_PTRHI = 2;
  localparam int OFS_PTRLO = 3;
  localparam int OFS_ISEL  = 4;
  localparam int OFS_BSEL  = 5;
  localparam int OFS_WSEL  = 6;

  typedef struct packed {
    logic commit;     // load pending status
    logic markFlush;  // show FLUSH during handshake
    logic ldPtr;      // accept command pointer write
    logic ldDev;      // write device status bits
    logic ldIsel;
    logic ldBsel;
    logic ldWsel;
  } strobeT;

endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_regs_pkg::*;
#(
  parameter int WIDX_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WIDX_W-1:0]  wordIdx,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic [HALF_W-1:0]  statusCur,
  input  logic               flushAck,
  output strobeT             strb,
  output logic [HALF_W-1:0]  pendStatus,
  output logic               flushReq,
  output logic               kick
);

  typedef enum logic {ST_IDLE, ST_FLUSH} ctlStateT;

  ctlStateT          stateQ;
  logic [HALF_W-1:0] heldQ;
  logic [HALF_W-1:0] nextSt;
  logic [HALF_W-1:0] wMask;
  logic [HALF_W-1:0] wVal;
  logic              flushBit;
  logic              stopOut;
  logic              ctlHit;
  logic              needFlush;
  logic              wakeReq;

  assign wMask = regWrData[WORD_W-1:HALF_W];
  assign wVal  = regWrData[HALF_W-1:0];

  always_comb begin
    nextSt = statusCur;
    nextSt[BIT_FLUSH] = 1'b0;
    if (wMask[BIT_RUN]) begin
      if (wVal[BIT_RUN]) begin
        nextSt[BIT_RUN] = 1'b1;
      end else begin
        nextSt[BIT_RUN]  = 1'b0;
        nextSt[BIT_DEAD] = 1'b0;
      end
    end
    wakeReq = wMask[BIT_WAKE] && wVal[BIT_WAKE];
    if (wakeReq && nextSt[BIT_RUN]) nextSt[BIT_WAKE] = 1'b1;
    if (wMask[BIT_PAUSE]) nextSt[BIT_PAUSE] = wVal[BIT_PAUSE];
    flushBit = wMask[BIT_FLUSH] && wVal[BIT_FLUSH];
    stopOut  = nextSt[BIT_PAUSE] || !nextSt[BIT_RUN];
    if (stopOut)
      nextSt[BIT_ACTIVE] = 1'b0;
    else if (wMask[BIT_RUN] || wMask[BIT_PAUSE] || wakeReq)
      nextSt[BIT_ACTIVE] = 1'b1;
  end

  always_comb begin
    ctlHit    = wrEn && (wordIdx == WIDX_W'(OFS_CTRL)) && (stateQ == ST_IDLE);
    needFlush = ctlHit && (stopOut || flushBit);
    strb.commit    = (ctlHit && !needFlush) || ((stateQ == ST_FLUSH) && flushAck);
    strb.markFlush = needFlush && flushBit;
    strb.ldPtr     = wrEn && (wordIdx == WIDX_W'(OFS_PTRLO)) && !statusCur[BIT_ACTIVE];
    strb.ldDev     = wrEn && (wordIdx == WIDX_W'(OFS_STAT));
    strb.ldIsel    = wrEn && (wordIdx == WIDX_W'(OFS_ISEL));
    strb.ldBsel    = wrEn && (wordIdx == WIDX_W'(OFS_BSEL));
    strb.ldWsel    = wrEn && (wordIdx == WIDX_W'(OFS_WSEL));
    pendStatus     = (stateQ == ST_FLUSH) ? heldQ : nextSt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      heldQ  <= '0;
      kick   <= 1'b0;
    end else begin
      kick <= strb.commit && pendStatus[BIT_ACTIVE];
      case (stateQ)
        ST_IDLE: if (needFlush) begin
          stateQ <= ST_FLUSH;
          heldQ  <= nextSt;
        end
        ST_FLUSH: if (flushAck) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign flushReq = (stateQ == ST_FLUSH);

  // R6: request held until acknowledged
  assert_flush_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && !flushAck |=> flushReq);

  // R7: FLUSH status bit only visible during the handshake
  assert_flush_bit_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusCur[BIT_FLUSH] |-> flushReq);

  // R8: kick only follows a commit that left the channel active
  assert_kick_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    kick |-> statusCur[BIT_ACTIVE]);

endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_regs_pkg::*;
#(
  parameter int WIDX_W  = 6,
  parameter int DEV_W   = 8,
  parameter int PTR_LSB = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [HALF_W-1:0]  pendStatus,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic [WIDX_W-1:0]  wordIdx,
  input  logic               rdAligned,
  input  logic               seqFetch,
  input  logic               seqHalt,
  input  logic               seqKill,
  input  logic               seqBranch,
  input  logic               seqBtVal,
  output logic [WORD_W-1:0]  regRdData,
  output logic [HALF_W-1:0]  statusQ,
  output logic [WORD_W-1:0]  cmdPtr,
  output logic [WORD_W-1:0]  intSel,
  output logic [WORD_W-1:0]  brSel,
  output logic [WORD_W-1:0]  waitSel,
  output logic               fetchReq
);

  logic [HALF_W-1:0] statusNxt;

  always_comb begin
    statusNxt = statusQ;
    if (strb.commit) begin
      statusNxt = pendStatus;
    end else begin
      if (seqFetch) statusNxt[BIT_WAKE] = 1'b0;
      if (seqHalt)  statusNxt[BIT_ACTIVE] = 1'b0;
      if (seqKill) begin
        statusNxt[BIT_DEAD]   = 1'b1;
        statusNxt[BIT_ACTIVE] = 1'b0;
      end
      if (seqBranch) statusNxt[BIT_BT] = seqBtVal;
      if (strb.markFlush) statusNxt[BIT_FLUSH] = 1'b1;
      if (strb.ldDev) statusNxt[DEV_W-1:0] = regWrData[DEV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      cmdPtr   <= '0;
      intSel   <= '0;
      brSel    <= '0;
      waitSel  <= '0;
      fetchReq <= 1'b0;
    end else begin
      statusQ  <= statusNxt;
      fetchReq <= strb.ldPtr;
      if (strb.ldPtr)  cmdPtr  <= {regWrData[WORD_W-1:PTR_LSB], PTR_LSB'(0)};
      if (strb.ldIsel) intSel  <= regWrData;
      if (strb.ldBsel) brSel   <= regWrData;
      if (strb.ldWsel) waitSel <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (rdAligned) begin
      case (wordIdx)
        WIDX_W'(OFS_CTRL),
        WIDX_W'(OFS_STAT):  regRdData = {{(WORD_W-HALF_W){1'b0}}, statusQ};
        WIDX_W'(OFS_PTRLO): regRdData = cmdPtr;
        WIDX_W'(OFS_ISEL):  regRdData = intSel;
        WIDX_W'(OFS_BSEL):  regRdData = brSel;
        WIDX_W'(OFS_WSEL):  regRdData = waitSel;
        default:            regRdData = '0;
      endcase
    end
  end

  // R5: an active channel is always running and not paused
  assert_active_needs_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[BIT_ACTIVE] |-> statusQ[BIT_RUN] && !statusQ[BIT_PAUSE]);

  // R9: pointer frozen while the channel stays active
  assert_ptr_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[BIT_ACTIVE] && !strb.commit |=> $stable(cmdPtr));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DEV_W   = 8,
  parameter int PTR_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              flushReq,
  input  logic              flushAck,
  output logic              kick,
  output logic              fetchReq,
  output logic [31:0]       cmdPtr,
  output logic [15:0]       chanStatus,
  output logic [31:0]       intSel,
  output logic [31:0]       brSel,
  output logic [31:0]       waitSel,
  input  logic              seqFetch,
  input  logic              seqHalt,
  input  logic              seqKill,
  input  logic              seqBranch,
  input  logic              seqBtVal
);

  localparam int WIDX_W = ADDR_W - 2;

  logic              aligned;
  logic [WIDX_W-1:0] wordIdx;
  strobeT            strb;
  logic [HALF_W-1:0] pendStatus;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign wordIdx = regAddr[ADDR_W-1:2];

  dma_chan_ctl #(.WIDX_W(WIDX_W)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (regWrEn && aligned),
    .wordIdx    (wordIdx),
    .regWrData  (regWrData),
    .statusCur  (chanStatus),
    .flushAck   (flushAck),
    .strb       (strb),
    .pendStatus (pendStatus),
    .flushReq   (flushReq),
    .kick       (kick)
  );

  dma_chan_dp #(.WIDX_W(WIDX_W), .DEV_W(DEV_W), .PTR_LSB(PTR_LSB)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pendStatus (pendStatus),
    .regWrData  (regWrData),
    .wordIdx    (wordIdx),
    .rdAligned  (aligned),
    .seqFetch   (seqFetch),
    .seqHalt    (seqHalt),
    .seqKill    (seqKill),
    .seqBranch  (seqBranch),
    .seqBtVal   (seqBtVal),
    .regRdData  (regRdData),
    .statusQ    (chanStatus),
    .cmdPtr     (cmdPtr),
    .intSel     (intSel),
    .brSel      (brSel),
    .waitSel    (waitSel),
    .fetchReq   (fetchReq)
  );

endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        flushReq, kick, fetchReq;
  logic        flushAck = 1'b0;
  logic [31:0] cmdPtr, intSel, brSel, waitSel;
  logic [15:0] chanStatus;
  logic        seqFetch = 1'b0, seqHalt = 1'b0, seqKill = 1'b0;
  logic        seqBranch = 1'b0, seqBtVal = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .flushReq(flushReq),
    .flushAck(flushAck), .kick(kick), .fetchReq(fetchReq), .cmdPtr(cmdPtr),
    .chanStatus(chanStatus), .intSel(intSel), .brSel(brSel), .waitSel(waitSel),
    .seqFetch(seqFetch), .seqHalt(seqHalt), .seqKill(seqKill),
    .seqBranch(seqBranch), .seqBtVal(seqBtVal)
  );

  // {control word, status while flushing, status after commit, flush expected}
  localparam logic [64:0] VEC [8] = '{
    {32'h8000_8000, 16'h0000, 16'h8400, 1'b0},
    {32'h4000_4000, 16'h8400, 16'hC000, 1'b1},
    {32'h4000_0000, 16'h0000, 16'h8400, 1'b0},
    {32'h2000_2000, 16'hA400, 16'h8400, 1'b1},
    {32'h0000_FFFF, 16'h0000, 16'h8400, 1'b0},
    {32'h8000_0000, 16'h8400, 16'h0000, 1'b1},
    {32'h1000_1000, 16'h0000, 16'h0000, 1'b1},
    {32'h9000_9000, 16'h0000, 16'h9400, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic ack();
    flushAck = 1'b1;
    @(negedge clk);
    flushAck = 1'b0;
  endtask

  task automatic seqPulse(input int which, input logic bt);
    @(negedge clk);
    case (which)
      0: seqFetch = 1'b1;
      1: seqHalt = 1'b1;
      2: seqKill = 1'b1;
      default: begin seqBranch = 1'b1; seqBtVal = bt; end
    endcase
    @(negedge clk);
    seqFetch = 1'b0; seqHalt = 1'b0; seqKill = 1'b0; seqBranch = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 outputs", {29'b0, flushReq, kick, fetchReq}, 32'h0);

    // R2..R8 via control-word table
    for (int i = 0; i < 8; i++) begin
      logic [31:0] wd;
      logic [15:0] expDur, expSt;
      logic        expF;
      {wd, expDur, expSt, expF} = VEC[i];
      wr(8'h00, wd);
      chk($sformatf("R6 flushReq vec%0d", i), {31'b0, flushReq}, {31'b0, expF});
      if (expF) begin
        chk($sformatf("R7 status during flush vec%0d", i), {16'b0, chanStatus}, {16'b0, expDur});
        ack();
        chk($sformatf("R6 flushReq drop vec%0d", i), {31'b0, flushReq}, 32'h0);
      end
      rd(8'h00, v);
      chk($sformatf("R5 R2 R3 R4 status vec%0d", i), v, {16'b0, expSt});
      chk($sformatf("R8 kick vec%0d", i), {31'b0, kick}, {31'b0, expSt[10]});
    end

    // R12: fetch clears WAKE
    seqPulse(0, 1'b0);
    chk("R12 fetch clears wake", {16'b0, chanStatus}, 32'h8400);

    // R9: pointer write while active ignored
    wr(8'h0C, 32'h1000_0040);
    chk("R9 ignored fetchReq", {31'b0, fetchReq}, 32'h0);
    rd(8'h0C, v);
    chk("R9 ignored ptr", v, 32'h0);

    // R12: branch loads BT
    seqPulse(3, 1'b1);
    chk("R12 branch set", {16'b0, chanStatus}, 32'h8500);
    seqPulse(3, 1'b0);
    chk("R12 branch clear", {16'b0, chanStatus}, 32'h8400);

    // R6: control write during flush dropped
    wr(8'h00, 32'h4000_4000);
    chk("R6 flush started", {31'b0, flushReq}, 32'h1);
    wr(8'h00, 32'h2000_2000);
    chk("R6 no flush mark from dropped write", {16'b0, chanStatus}, 32'h8400);
    ack();
    chk("R6 commit after drop", {16'b0, chanStatus}, 32'hC000);
    chk("R6 no second flush", {31'b0, flushReq}, 32'h0);
    wr(8'h00, 32'h4000_0000);
    chk("R5 resume", {16'b0, chanStatus}, 32'h8400);

    // R12: kill
    seqPulse(2, 1'b0);
    chk("R12 kill", {16'b0, chanStatus}, 32'h8800);

    // R5: untouched write keeps ACTIVE clear, no flush, no kick
    wr(8'h00, 32'h0000_0000);
    chk("R5 no flush", {31'b0, flushReq}, 32'h0);
    chk("R5 unchanged", {16'b0, chanStatus}, 32'h8800);
    chk("R8 no kick", {31'b0, kick}, 32'h0);

    // R2: clearing RUN clears DEAD
    wr(8'h00, 32'h8000_0000);
    ack();
    chk("R2 dead cleared", {16'b0, chanStatus}, 32'h0);

    // R9: accepted pointer write
    wr(8'h0C, 32'h1234_567F);
    chk("R9 fetchReq pulse", {31'b0, fetchReq}, 32'h1);
    chk("R9 ptr aligned", cmdPtr, 32'h1234_5670);
    @(negedge clk);
    chk("R9 fetchReq one cycle", {31'b0, fetchReq}, 32'h0);

    // R11: status write only device bits
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v);
    chk("R11 status write", v, 32'h0000_00FF);

    // R10: selects, zero reads
    wr(8'h10, 32'hA5A5_0001);
    wr(8'h14, 32'h5A5A_0002);
    wr(8'h18, 32'h0F0F_0003);
    wr(8'h08, 32'hDEAD_BEEF);
    rd(8'h10, v); chk("R10 int select", v, 32'hA5A5_0001);
    rd(8'h14, v); chk("R10 branch select", v, 32'h5A5A_0002);
    rd(8'h18, v); chk("R10 wait select", v, 32'h0F0F_0003);
    chk("R10 select ports", intSel ^ brSel ^ waitSel, 32'hF0F0_0000);
    rd(8'h08, v); chk("R10 ptr high zero", v, 32'h0);
    rd(8'h1C, v); chk("R10 unused zero", v, 32'h0);
    rd(8'h40, v); chk("R10 out of window zero", v, 32'h0);
    rd(8'h11, v); chk("R10 misaligned zero", v, 32'h0);

    // R12: halt
    wr(8'h00, 32'h8000_8000);
    chk("R8 kick on start", {31'b0, kick}, 32'h1);
    seqPulse(1, 1'b0);
    chk("R12 halt", {16'b0, chanStatus}, 32'h80FF);

    // R1: reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    rd(8'h00, v);
    chk("R1 status after reset", v, 32'h0);
    chk("R1 ptr after reset", cmdPtr, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule